// File: doc/BRIEF.md
# Opposite-Neighbour Transition Avoidance Bus Codec

This block sits on both ends of a long on-chip parallel bus. It drives the bus so that no wire switches against both of its neighbours at the same time. That simultaneous three-wire pattern is the worst case for coupling capacitance, and therefore for delay. Each 3-bit slice of the payload travels on four wires: three body wires and one polarity wire. When the polarity wire is high, the body carries the complement of the slice. The receiving side undoes the complement by XOR-ing each body with its own polarity bit. No other state is needed to decode.

The encoder holds the word currently on the bus in a register that clears to zero under reset. Each cycle it forms every combination of per-slice complements for the incoming payload. It counts the worst-case events that each combination would create against the held word, keeps the combination with the fewest, and registers it as the next bus word. Wires at the slice boundaries, the polarity wires included, are counted the same as wires inside a slice.

With three or more slices, some rare previous-word and payload pairs have no combination that is free of events. In those cases the encoder still sends the combination with the fewest events. Milder transitions, in which at most one neighbour opposes, are never acted on.

Top module: `xt_guard_codec`

## Requirements
- R1: While `rst` is high at a rising clock edge, `bus_o` becomes all zeros after that edge, and `rx_data_o` therefore reads all zeros.
- R2: Bus layout for slice g: wires 4g, 4g+1 and 4g+2 carry payload bits 3g, 3g+1 and 3g+2 XOR the polarity bit, and wire 4g+3 carries the polarity bit. A payload sampled at a rising edge is on `bus_o` right after that edge.
- R3: `rx_data_o` is combinational from the registered bus word: each slice body XOR its replicated polarity bit. It equals the payload that was sampled at the previous edge.
- R4: A worst-case event at wire i (0 < i < wires-1) means wire i toggles in one direction while wires i-1 and i+1 both toggle in the other direction, between the held word and the next word. The outermost two wires are never event centres. Whenever some complement combination yields zero events, the next bus word has none.
- R5: Complement combinations are numbered by a vector with bit g set when slice g is complemented. The encoder sends the combination with the fewest events and breaks ties by the lowest vector value. As a result, the payload goes out uncomplemented whenever the plain word is event-free.
- R6: Events centred on a polarity wire, or on the first body wire of a slice, count the same as events inside a slice.
- R7: Transitions where wires move together, or where a neighbour is static, are not events. For example, 0x000 followed by 0xFFF is sent as 0x7777, and 0x7777 followed by payload 0x000 is sent as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| tx_data_i | input | GROUPS*3 | Payload to send, sampled every rising edge |
| bus_o | output | GROUPS*4 | Registered encoded bus word |
| rx_data_o | output | GROUPS*3 | Payload recovered from the bus word |

## Verification
A corrupted held word would show up on the very next edge. Every later choice is made against the wrong previous word, so `bus_o` would differ from a reference that tracks the intended bus. The same fault can also leave a worst-case event between consecutive words even though a clean combination existed. Because the reference predicts the exact word every cycle, a wrong tie-break or a miscounted boundary wire shows up as a mismatch within one cycle of the pattern that exposes it. A slip in decode or layout shows up at once as a difference between `rx_data_o` and the payload from one cycle earlier.

// File: rtl/xt_pkg.sv
package xt_pkg;

    localparam int GRP_DATA  = 3;
    localparam int GRP_WIRES = GRP_DATA + 1;

    // Direction of one wire between two consecutive bus words
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_RISE = 2'd1,
        DIR_FALL = 2'd2
    } dir_e;

    // One slice on the bus: polarity on the top wire, body below
    typedef struct packed {
        logic                inv;
        logic [GRP_DATA-1:0] body;
    } grp_word_t;

    function automatic dir_e wire_dir(input logic prev, input logic next);
        if (prev == next) return DIR_HOLD;
        return next ? DIR_RISE : DIR_FALL;
    endfunction

    function automatic logic is_opposite(input dir_e a, input dir_e b);
        return ((a == DIR_RISE) && (b == DIR_FALL)) ||
               ((a == DIR_FALL) && (b == DIR_RISE));
    endfunction

    // Independent formulation used by checks: all three toggle and the new
    // centre value differs from both new neighbour values.
    function automatic int unsigned count_events(input logic [63:0] p,
                                                 input logic [63:0] n,
                                                 input int unsigned w);
        int unsigned cnt;
        cnt = 0;
        for (int unsigned i = 1; i + 1 < w; i++) begin
            if ((p[i] != n[i]) && (p[i-1] != n[i-1]) && (p[i+1] != n[i+1]) &&
                (n[i-1] != n[i]) && (n[i+1] != n[i]))
                cnt++;
        end
        return cnt;
    endfunction

endpackage

// File: rtl/xt_cand_gen.sv
module xt_cand_gen
    import xt_pkg::*;
#(
    parameter int GROUPS = 4,
    localparam int DATA_W = GROUPS * GRP_DATA,
    localparam int WIRES  = GROUPS * GRP_WIRES
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [GROUPS-1:0] inv_i,
    output logic [WIRES-1:0]  bus_o
);

    for (genvar g = 0; g < GROUPS; g++) begin : g_slice
        grp_word_t word;
        assign word.inv  = inv_i[g];
        assign word.body = data_i[g*GRP_DATA +: GRP_DATA] ^ {GRP_DATA{inv_i[g]}};
        assign bus_o[g*GRP_WIRES +: GRP_WIRES] = word;
    end

endmodule

// File: rtl/xt_event_count.sv
module xt_event_count
    import xt_pkg::*;
#(
    parameter int WIRES = 16,
    parameter int CNT_W = 5
) (
    input  logic [WIRES-1:0] prev_i,
    input  logic [WIRES-1:0] next_i,
    output logic [CNT_W-1:0] count_o
);

    dir_e             dir [WIRES];
    logic [WIRES-1:0] hit;

    for (genvar i = 0; i < WIRES; i++) begin : g_dir
        assign dir[i] = wire_dir(prev_i[i], next_i[i]);
    end

    // Edge wires have a single neighbour and can never be a centre
    assign hit[0]       = 1'b0;
    assign hit[WIRES-1] = 1'b0;
    for (genvar i = 1; i < WIRES - 1; i++) begin : g_hit
        assign hit[i] = is_opposite(dir[i], dir[i-1]) &&
                        is_opposite(dir[i], dir[i+1]);
    end

    always_comb begin
        count_o = '0;
        for (int i = 0; i < WIRES; i++)
            count_o = count_o + CNT_W'(hit[i]);
    end

endmodule

// File: rtl/xt_pick.sv
module xt_pick #(
    parameter int NCAND = 16,
    parameter int CNT_W = 5,
    parameter int SEL_W = 4
) (
    input  logic [NCAND*CNT_W-1:0] cnt_i,
    output logic [SEL_W-1:0]       sel_o,
    output logic [CNT_W-1:0]       best_o
);

    // Strict less-than keeps the lowest index on a tie
    always_comb begin
        best_o = cnt_i[0 +: CNT_W];
        sel_o  = '0;
        for (int i = 1; i < NCAND; i++) begin
            if (cnt_i[i*CNT_W +: CNT_W] < best_o) begin
                best_o = cnt_i[i*CNT_W +: CNT_W];
                sel_o  = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/xt_dec.sv
module xt_dec
    import xt_pkg::*;
#(
    parameter int GROUPS = 4,
    localparam int DATA_W = GROUPS * GRP_DATA,
    localparam int WIRES  = GROUPS * GRP_WIRES
) (
    input  logic [WIRES-1:0]  bus_i,
    output logic [DATA_W-1:0] data_o
);

    for (genvar g = 0; g < GROUPS; g++) begin : g_slice
        grp_word_t word;
        assign word = bus_i[g*GRP_WIRES +: GRP_WIRES];
        assign data_o[g*GRP_DATA +: GRP_DATA] = word.body ^ {GRP_DATA{word.inv}};
    end

endmodule

// File: rtl/xt_guard_codec.sv
module xt_guard_codec
    import xt_pkg::*;
#(
    parameter int GROUPS = 4,
    localparam int DATA_W = GROUPS * GRP_DATA,
    localparam int WIRES  = GROUPS * GRP_WIRES,
    localparam int NCAND  = 1 << GROUPS,
    localparam int CNT_W  = $clog2(WIRES + 1),
    localparam int SEL_W  = GROUPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic [WIRES-1:0]  bus_o,
    output logic [DATA_W-1:0] rx_data_o
);

    logic [WIRES-1:0]       bus_q;
    logic [WIRES-1:0]       cand [NCAND];
    logic [NCAND*CNT_W-1:0] cnt_flat;
    logic [SEL_W-1:0]       sel;
    logic [CNT_W-1:0]       best_cnt;

    // One candidate word and one event counter per complement combination
    for (genvar c = 0; c < NCAND; c++) begin : g_cand
        xt_cand_gen #(.GROUPS(GROUPS)) u_gen (
            .data_i (tx_data_i),
            .inv_i  (SEL_W'(c)),
            .bus_o  (cand[c])
        );
        xt_event_count #(.WIRES(WIRES), .CNT_W(CNT_W)) u_cnt (
            .prev_i  (bus_q),
            .next_i  (cand[c]),
            .count_o (cnt_flat[c*CNT_W +: CNT_W])
        );
    end

    xt_pick #(.NCAND(NCAND), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_pick (
        .cnt_i  (cnt_flat),
        .sel_o  (sel),
        .best_o (best_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) bus_q <= '0;
        else     bus_q <= cand[sel];
    end

    assign bus_o = bus_q;

    xt_dec #(.GROUPS(GROUPS)) u_dec (
        .bus_i  (bus_q),
        .data_o (rx_data_o)
    );

    AST_RESET_BUS: assert property (@(posedge clk)
        rst |=> (bus_o == '0)); // R1

    AST_ROUNDTRIP: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (rx_data_o == $past(tx_data_i))); // R3

    AST_NO_4C: assert property (@(posedge clk) disable iff (rst)
        (best_cnt == '0) |=>
        (count_events(64'($past(bus_q)), 64'(bus_q), WIRES) == 0)); // R4

    AST_PLAIN_FIRST: assert property (@(posedge clk) disable iff (rst)
        (cnt_flat[0 +: CNT_W] == '0) |=> (bus_o == $past(cand[0]))); // R5

endmodule

// File: tb/xt_guard_codec_tb.sv
module xt_guard_codec_tb;

    localparam int CLK_PERIOD = 10;
    localparam int GROUPS     = 4;
    localparam int DW         = GROUPS * 3;
    localparam int WW         = GROUPS * 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] tx_data = '0;
    logic [WW-1:0] bus;
    logic [DW-1:0] rx_data;

    int checks   = 0;
    int failures = 0;
    int unavoidable = 0;
    bit done = 1'b0;

    logic [WW-1:0] exp_bus = '0;
    int            exp_min = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xt_guard_codec #(.GROUPS(GROUPS)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .tx_data_i (tx_data),
        .bus_o     (bus),
        .rx_data_o (rx_data)
    );

    // Reference: signed per-wire step, event when centre moves against both
    function automatic int ref_events(input logic [WW-1:0] p, input logic [WW-1:0] n);
        int cnt = 0;
        for (int i = 1; i < WW - 1; i++) begin
            int dl = int'(n[i-1]) - int'(p[i-1]);
            int dc = int'(n[i])   - int'(p[i]);
            int dr = int'(n[i+1]) - int'(p[i+1]);
            if (dc != 0 && dl == -dc && dr == -dc) cnt++;
        end
        return cnt;
    endfunction

    function automatic logic [WW-1:0] ref_word(input logic [DW-1:0] d, input int v);
        logic [WW-1:0] w = '0;
        for (int g = 0; g < GROUPS; g++) begin
            logic inv = v[g];
            for (int b = 0; b < 3; b++) w[4*g+b] = d[3*g+b] ^ inv;
            w[4*g+3] = inv;
        end
        return w;
    endfunction

    function automatic logic [WW-1:0] ref_encode(input logic [WW-1:0] prev,
                                                 input logic [DW-1:0] d,
                                                 output int min_cnt);
        logic [WW-1:0] best_w = '0;
        min_cnt = 1 << 30;
        for (int v = 0; v < (1 << GROUPS); v++) begin
            logic [WW-1:0] w = ref_word(d, v);
            int c = ref_events(prev, w);
            if (c < min_cnt) begin
                min_cnt = c;
                best_w  = w;
            end
        end
        return best_w;
    endfunction

    task automatic check_bus(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s bus actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_data(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s data actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s count actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge
    task automatic send(input logic [DW-1:0] d, input string req);
        logic [WW-1:0] prev = exp_bus;
        int m;
        tx_data = d;
        exp_bus = ref_encode(prev, d, m);
        exp_min = m;
        @(negedge clk);
        check_bus(req, bus, exp_bus);
        check_data("R3", rx_data, d);
        if (m == 0) check_int("R4", ref_events(prev, bus), 0);
        else unavoidable++;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bus("R1", bus, '0);
        check_data("R1", rx_data, '0);
        rst = 1'b0;

        // R7 / R2: nothing falls, plain layout
        send(12'hFFF, "R7");
        check_bus("R2", bus, 16'h7777);
        // R7: all falling together is not an event
        send(12'h000, "R7");
        check_bus("R7", bus, 16'h0000);
        // R5: plain word goes out uncomplemented
        send(12'h002, "R5");
        check_bus("R5", bus, 16'h0002);
        // R4: plain 101 over 010 would hit wire 1; slice 0 complemented
        send(12'h005, "R4");
        check_bus("R4", bus, 16'h000A);
        check_data("R3", rx_data, 12'h005);
        // R6: patterns that straddle slice boundaries and polarity wires
        send(12'h015, "R6");
        send(12'h02A, "R6");
        send(12'h1C7, "R6");
        send(12'h238, "R6");
        send(12'hAAA, "R6");
        send(12'h555, "R6");

        // R1: reset in the middle of traffic
        tx_data = 12'h9C3;
        rst = 1'b1;
        @(negedge clk);
        check_bus("R1", bus, '0);
        check_data("R1", rx_data, '0);
        rst = 1'b0;
        exp_bus = '0;

        // R5 / R4 / R3 over random traffic
        for (int k = 0; k < 4000; k++) send(DW'($urandom), "R5");
        for (int k = 0; k < 500; k++) send(DW'($urandom) & 12'h555, "R6");

        $display("info: %0d words had no event-free choice", unavoidable);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule